// File: doc/BRIEF.md
# Odd-Multiple Table Constant Multiplier

This block multiplies a 5-bit unsigned operand by a positive coefficient that is fixed at elaboration time. No general multiplier is built. A small constant table holds only the odd multiples 1·A through 15·A, plus a zero word. The trailing zeros of the operand's low nibble set a left shift, and that shift rebuilds every even multiple from its odd part. When the operand's top bit is set, a constant 16·A is added after the shift.

Operands enter with a valid strobe and pass through one input register stage and one output register stage. A result therefore appears a fixed two cycles after the operand is accepted. The block fits filters and interpolators where one tap's weight never changes.

Top module: `oddlut_mul`

## Requirements
- R1: When out_valid is high, out_prod equals the operand accepted two cycles earlier multiplied by COEF. The product is exact and unsigned.
- R2: out_valid is high in a cycle exactly when in_valid was high two rising edges earlier. Operands may arrive back to back every cycle.
- R3: While rst is high at a rising edge, out_valid and out_prod are cleared to zero at that edge.
- R4: While out_valid is low, out_prod keeps its last value. Operands presented with in_valid low do not change it.
- R5: Operands whose low nibble is nonzero and even, for example 2, 4, 8, 12 and 14, give the exact product. The shift count is the number of trailing zero bits of the low nibble.
- R6: A low nibble of zero selects the zero word. Operand 0 gives 0 and operand 16 gives 16·COEF.
- R7: Bit 4 of the operand adds 16·COEF to the result of the low nibble. Operand 31 gives 31·COEF.
- R8: out_prod is CW+5 bits wide. It holds 31·COEF without overflow for any COEF that fits in CW bits, including 2^CW−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_x | input | 5 | Unsigned operand |
| out_valid | output | 1 | Product strobe, two cycles after in_valid |
| out_prod | output | CW+5 | Product in_x·COEF |

## Verification
The bench builds four copies of the block with CW = 8. Their coefficients are 1, 13, 170 and 255. All four see the same stream of operands. Coefficient 1 shows the shift and offset paths with no masking from the table. Coefficients 170 and 255 push the table words and the final sum to the full output width. Each copy receives all 32 operands back to back, so every shift count, the zero-nibble case and both values of the top bit are covered for each coefficient. A separate isolated operand, followed by idle cycles with changing inputs and then a reset in mid-run, covers the timing of the strobe and the hold and clear behaviour.

// File: rtl/oddlut_mul.sv
module oddlut_mul #(
  parameter int          CW   = 8,
  parameter int unsigned COEF = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    in_x,
  output logic          out_valid,
  output logic [CW+4:0] out_prod
);
  localparam int PW = CW + 5;
  localparam int TW = CW + 4;
  localparam logic [PW-1:0] C16 = PW'(COEF) << 4;

  logic [4:0] x_q;
  logic       v_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0;
      v_q <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) x_q <= in_x;
    end
  end

  // shift control: trailing zeros of the low nibble, capped at 3
  logic [3:0] nib;
  logic       s1, s0;
  logic [1:0] sh;
  assign nib = x_q[3:0];
  assign s1  = ~(nib[0] | nib[1]);
  assign s0  = ~(nib[0] | ~(nib[1] | ~nib[2]));
  assign sh  = {s1, s0};

  // table address: odd part index, or the zero word at 8
  logic [3:0] odd_part;
  logic [3:0] addr;
  assign odd_part = nib >> sh;
  assign addr     = (nib == 4'd0) ? 4'd8 : {1'b0, odd_part[3:1]};

  logic [TW-1:0] tbl [16];
  for (genvar g = 0; g < 16; g++) begin : g_tbl
    if (g < 8) begin : g_odd
      assign tbl[g] = TW'((2 * g + 1) * COEF);
    end else begin : g_zero
      assign tbl[g] = '0;
    end
  end

  logic [TW-1:0] word;
  logic [PW-1:0] shifted;
  logic [PW-1:0] sum;
  assign word    = tbl[addr];
  assign shifted = PW'(word) << sh;
  assign sum     = shifted + (x_q[4] ? C16 : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
    end else begin
      out_valid <= v_q;
      if (v_q) out_prod <= sum;
    end
  end
endmodule

// File: rtl/oddlut_mul_chk.sv
module oddlut_mul_chk #(
  parameter int          CW   = 8,
  parameter int unsigned COEF = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [4:0]    in_x,
  input logic          out_valid,
  input logic [CW+4:0] out_prod
);
  localparam int PW = CW + 5;
  localparam logic [PW-1:0] PMAX = PW'(31 * COEF);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R1
  product_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid) |-> (out_prod == PW'(COEF) * PW'($past(in_x, 2))));

  // R3
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_prod == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !out_valid) |-> $stable(out_prod));

  // R8
  range_chk: assert property (@(posedge clk) disable iff (rst)
    out_prod <= PMAX);
endmodule

bind oddlut_mul oddlut_mul_chk #(.CW(CW), .COEF(COEF)) u_chk (.*);

// File: tb/oddlut_mul_tb.sv
module oddlut_mul_tb;
  localparam int CW = 8;
  localparam int PW = CW + 5;
  localparam int NC = 4;
  localparam int unsigned COEFS [NC] = '{1, 13, 170, 255};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [4:0] in_x = '0;
  logic          vld  [NC];
  logic [PW-1:0] prod [NC];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  for (genvar c = 0; c < NC; c++) begin : g_c
    oddlut_mul #(.CW(CW), .COEF(COEFS[c])) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
      .out_valid(vld[c]), .out_prod(prod[c])
    );
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(int x);
    if (x == 31) return "R8";
    if (x[3:0] == 0) return "R6";
    if (x[3:0] != 0 && x[0] == 1'b0) return "R5";
    if (x[4]) return "R7";
    return "R1";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(vld[c] == 1'b0, "R3", vld[c], 0);
      chk(prod[c] == '0, "R3", prod[c], 0);
    end
    rst = 1'b0;

    // back-to-back sweep of all 32 operands
    for (int i = 0; i < 34; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        for (int c = 0; c < NC; c++) begin
          chk(vld[c] == 1'b1, "R2", vld[c], 1);
          chk(prod[c] == PW'((i - 2) * COEFS[c]), tag_of(i - 2),
              prod[c], (i - 2) * COEFS[c]);
        end
      end
      in_valid = (i < 32);
      in_x = 5'(i);
    end

    // idle: operands change without in_valid
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        chk(vld[c] == 1'b0, "R2", vld[c], 0);
        chk(prod[c] == PW'(31 * COEFS[c]), "R4", prod[c], 31 * COEFS[c]);
      end
      in_x = 5'(k * 7 + 3);
    end

    // isolated operand
    in_valid = 1'b1; in_x = 5'd12;
    @(negedge clk);
    in_valid = 1'b0; in_x = 5'd25;
    for (int c = 0; c < NC; c++) chk(vld[c] == 1'b0, "R2", vld[c], 0);
    @(negedge clk);
    in_x = 5'd9;
    for (int c = 0; c < NC; c++) begin
      chk(vld[c] == 1'b1, "R2", vld[c], 1);
      chk(prod[c] == PW'(12 * COEFS[c]), "R5", prod[c], 12 * COEFS[c]);
    end
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(vld[c] == 1'b0, "R2", vld[c], 0);
      chk(prod[c] == PW'(12 * COEFS[c]), "R4", prod[c], 12 * COEFS[c]);
    end

    // reset in mid-run with an operand in flight
    in_valid = 1'b1; in_x = 5'd16;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      chk(vld[c] == 1'b0, "R3", vld[c], 0);
      chk(prod[c] == '0, "R3", prod[c], 0);
    end
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk(vld[c] == 1'b0, "R3", vld[c], 0);

    // R6: operand 16 after reset
    in_valid = 1'b1; in_x = 5'd16;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NC; c++)
      chk(prod[c] == PW'(16 * COEFS[c]), "R6", prod[c], 16 * COEFS[c]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule